// File: doc/BRIEF.md
# End-of-Interrupt Handler with Storm Throttle

This block sits beside the redirection table of an interrupt router and handles end-of-interrupt notifications. Each notification carries an 8-bit vector. The block compares that vector against every pin's entry. A pin matches when it has the same vector, is level-triggered and is still waiting for its acknowledge. Every matching pin has its acknowledge flag cleared through a one-cycle clear strobe. The matching pins are visited one per clock, lowest pin first.

A pin whose line is still asserted and which is not masked needs service again. For such a pin the block normally raises a re-service request at once. Each pin also keeps a counter of back-to-back immediate re-deliveries. When that counter reaches a storm limit, the block does not request service at once. It clears the counter and starts a single shared delay timer instead. The request is raised when the timer expires.

Software may rewrite a pin's entry, and that write clears the pin's counter. The notification can come from two sources. One is a broadcast from the local interrupt controller. The other is a direct write to an acknowledge register, which is honoured only when the block's version code allows it.

Top module: `eoi_storm_throttle`

## Requirements
- R1: A pin matches a notification only when its vector field equals `eoiVector`, its `entLevel` bit is 1 (level-triggered) and its `entRemoteIrr` bit is 1. Any other pin receives no clear strobe.
- R2: Each matching pin gets exactly one clear pulse on `remoteIrrClr`. The pulses come in ascending pin order, one pin per cycle. The first pulse is in the cycle after the clock edge that samples the notification. At most one bit of `remoteIrrClr` is high in any cycle.
- R3: When the visited pin is unmasked (`entMask` = 0), its `pending` bit is 1 and its counter plus one is below `STORM_LIMIT`, the counter increments and `serviceReq` is high in the following cycle.
- R4: When the visited pin is masked or not pending, no request is raised for it and its counter returns to zero.
- R5: When the visited pin would reach `STORM_LIMIT`, its counter returns to zero and no immediate request is raised. Instead, `serviceReq` rises `DELAY_CYCLES` cycles later than an immediate request would have.
- R6: A pulse on `entryWrite[i]` returns pin i's counter to zero. It takes priority over any count update to that pin in the same cycle.
- R7: A notification with `eoiFromReg` = 1 is ignored unless `hwVersion` equals `EXPLICIT_VER` (0x20). A notification with `eoiFromReg` = 0 is always accepted.
- R8: If a storm arms the timer while it is already running, the earlier deadline is kept and only one deferred request is produced.
- R9: After reset, `remoteIrrClr` is all zero and `serviceReq` is low.
- R10: A notification that arrives while earlier matches are still being visited adds its own matches to the pins still to be visited. Nothing is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| eoiValid | input | 1 | End-of-interrupt notification strobe |
| eoiFromReg | input | 1 | 1 = direct register write, 0 = broadcast |
| eoiVector | input | VEC_W | Vector being acknowledged |
| hwVersion | input | 8 | Version code of the router |
| entVector | input | NUM_PINS*VEC_W | Vector field of each pin's entry, pin i at bits [i*VEC_W +: VEC_W] |
| entLevel | input | NUM_PINS | 1 = level-triggered pin |
| entMask | input | NUM_PINS | 1 = pin masked |
| entRemoteIrr | input | NUM_PINS | Acknowledge-outstanding flag of each pin |
| pending | input | NUM_PINS | Pin's request still asserted |
| entryWrite | input | NUM_PINS | Pulse when software writes either half of a pin's entry |
| remoteIrrClr | output | NUM_PINS | One-cycle strobe clearing a pin's acknowledge flag |
| serviceReq | output | 1 | Request for a service pass over the pins |

## Verification
A notification is sampled on one rising edge. The clear pulse for the lowest matching pin is visible during the next cycle, and each further match follows one cycle after the previous one. The immediate request for a visited pin is visible one cycle after that pin's clear pulse. A deferred request comes exactly `DELAY_CYCLES` cycles after the point where the immediate request would have been. The bench drives and samples on the falling edge, counts cycles from the notification, and checks each output in the exact cycle it is due. It also checks that the output is quiet in the cycles on either side. This catches an off-by-one in the timer or a restarted deadline.

// File: rtl/eoi_throttle_pkg.sv
package eoi_throttle_pkg;
  // strobes from the control to the datapath for the pin being visited
  typedef struct packed {
    logic bump;   // count one more immediate re-delivery
    logic zero;   // return the counter to zero
  } eoiStrobe_t;
endpackage

// File: rtl/eoi_throttle_dp.sv
module eoi_throttle_dp
  import eoi_throttle_pkg::*;
#(
  parameter int NUM_PINS    = 24,
  parameter int VEC_W       = 8,
  parameter int STORM_LIMIT = 10000,
  parameter logic [7:0] EXPLICIT_VER = 8'h20
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      eoiValid,
  input  logic                      eoiFromReg,
  input  logic [VEC_W-1:0]          eoiVector,
  input  logic [7:0]                hwVersion,
  input  logic [NUM_PINS*VEC_W-1:0] entVector,
  input  logic [NUM_PINS-1:0]       entLevel,
  input  logic [NUM_PINS-1:0]       entMask,
  input  logic [NUM_PINS-1:0]       entRemoteIrr,
  input  logic [NUM_PINS-1:0]       pending,
  input  logic [NUM_PINS-1:0]       entryWrite,
  input  eoiStrobe_t                strobe,
  output logic                      pickValid,
  output logic                      pickMasked,
  output logic                      pickPending,
  output logic                      pickStorm,
  output logic [NUM_PINS-1:0]       remoteIrrClr,
  output logic [NUM_PINS-1:0]       workSet
);
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int CNT_W = $clog2(STORM_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STORM_LIMIT - 1);

  logic                accept;
  logic [NUM_PINS-1:0] matchVec;
  logic [NUM_PINS-1:0] pickOneHot;
  logic [IDX_W-1:0]    pickIdx;
  logic [NUM_PINS-1:0][CNT_W-1:0] cntArr;

  assign accept = eoiValid && (!eoiFromReg || hwVersion == EXPLICIT_VER);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_match
    assign matchVec[g] = accept && entLevel[g] && entRemoteIrr[g] &&
                         (entVector[g*VEC_W +: VEC_W] == eoiVector);
  end

  // lowest pin still to be visited
  assign pickOneHot = workSet & (~workSet + NUM_PINS'(1));

  always_comb begin
    pickIdx = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (workSet[i]) pickIdx = IDX_W'(i);
    end
  end

  assign pickValid    = |workSet;
  assign pickMasked   = entMask[pickIdx];
  assign pickPending  = pending[pickIdx];
  assign pickStorm    = cntArr[pickIdx] >= LAST_CNT;
  assign remoteIrrClr = pickOneHot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      workSet <= '0;
    end else begin
      workSet <= (workSet | matchVec) & ~pickOneHot;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntArr <= '0;
    end else begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (entryWrite[i]) begin
          cntArr[i] <= '0;
        end else if (pickOneHot[i] && strobe.zero) begin
          cntArr[i] <= '0;
        end else if (pickOneHot[i] && strobe.bump) begin
          cntArr[i] <= cntArr[i] + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/eoi_throttle_ctrl.sv
module eoi_throttle_ctrl
  import eoi_throttle_pkg::*;
#(
  parameter int DELAY_CYCLES = 2000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pickValid,
  input  logic       pickMasked,
  input  logic       pickPending,
  input  logic       pickStorm,
  output eoiStrobe_t strobe,
  output logic       serviceReq,
  output logic       timerRunning
);
  localparam int TMR_W = $clog2(DELAY_CYCLES + 1);

  logic             live;
  logic             arm;
  logic             expire;
  logic [TMR_W-1:0] timerLeft;

  assign live        = pickValid && !pickMasked && pickPending;
  assign strobe.bump = live && !pickStorm;
  assign strobe.zero = pickValid && !(live && !pickStorm);
  assign arm         = live && pickStorm;
  assign expire      = timerRunning && (timerLeft == TMR_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerRunning <= 1'b0;
      timerLeft    <= '0;
    end else if (timerRunning) begin
      // a running deadline is always the earlier one: a new arm is dropped
      if (expire) timerRunning <= 1'b0;
      else        timerLeft    <= timerLeft - TMR_W'(1);
    end else if (arm) begin
      timerRunning <= 1'b1;
      timerLeft    <= TMR_W'(DELAY_CYCLES);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) serviceReq <= 1'b0;
    else       serviceReq <= strobe.bump || expire;
  end
endmodule

// File: rtl/eoi_storm_throttle.sv
module eoi_storm_throttle
  import eoi_throttle_pkg::*;
#(
  parameter int NUM_PINS     = 24,
  parameter int VEC_W        = 8,
  parameter int STORM_LIMIT  = 10000,
  parameter int DELAY_CYCLES = 2000000,
  parameter logic [7:0] EXPLICIT_VER = 8'h20
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      eoiValid,
  input  logic                      eoiFromReg,
  input  logic [VEC_W-1:0]          eoiVector,
  input  logic [7:0]                hwVersion,
  input  logic [NUM_PINS*VEC_W-1:0] entVector,
  input  logic [NUM_PINS-1:0]       entLevel,
  input  logic [NUM_PINS-1:0]       entMask,
  input  logic [NUM_PINS-1:0]       entRemoteIrr,
  input  logic [NUM_PINS-1:0]       pending,
  input  logic [NUM_PINS-1:0]       entryWrite,
  output logic [NUM_PINS-1:0]       remoteIrrClr,
  output logic                      serviceReq
);
  eoiStrobe_t          strobe;
  logic                pickValid;
  logic                pickMasked;
  logic                pickPending;
  logic                pickStorm;
  logic                timerRunning;
  logic [NUM_PINS-1:0] workSet;

  eoi_throttle_dp #(
    .NUM_PINS(NUM_PINS), .VEC_W(VEC_W),
    .STORM_LIMIT(STORM_LIMIT), .EXPLICIT_VER(EXPLICIT_VER)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .eoiValid(eoiValid), .eoiFromReg(eoiFromReg), .eoiVector(eoiVector),
    .hwVersion(hwVersion), .entVector(entVector), .entLevel(entLevel),
    .entMask(entMask), .entRemoteIrr(entRemoteIrr), .pending(pending),
    .entryWrite(entryWrite), .strobe(strobe),
    .pickValid(pickValid), .pickMasked(pickMasked), .pickPending(pickPending),
    .pickStorm(pickStorm), .remoteIrrClr(remoteIrrClr), .workSet(workSet)
  );

  eoi_throttle_ctrl #(.DELAY_CYCLES(DELAY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .pickValid(pickValid), .pickMasked(pickMasked), .pickPending(pickPending),
    .pickStorm(pickStorm), .strobe(strobe), .serviceReq(serviceReq),
    .timerRunning(timerRunning)
  );
endmodule

// File: rtl/eoi_storm_throttle_chk.sv
module eoi_storm_throttle_chk #(
  parameter int NUM_PINS = 24,
  parameter logic [7:0] EXPLICIT_VER = 8'h20
) (
  input logic                clk,
  input logic                rstN,
  input logic                eoiValid,
  input logic                eoiFromReg,
  input logic [7:0]          hwVersion,
  input logic [NUM_PINS-1:0] entMask,
  input logic [NUM_PINS-1:0] pending,
  input logic [NUM_PINS-1:0] remoteIrrClr,
  input logic                serviceReq,
  input logic [NUM_PINS-1:0] workSet,
  input logic                timerRunning
);
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(remoteIrrClr)); // R2

  AST_CLR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (remoteIrrClr != '0) |-> ($past(eoiValid) || $past(remoteIrrClr) != '0)); // R2

  AST_REG_EOI_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (eoiValid && eoiFromReg && hwVersion != EXPLICIT_VER && workSet == '0)
      |=> (remoteIrrClr == '0)); // R7

  AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    serviceReq |-> ($past(remoteIrrClr) != '0 || $past(timerRunning))); // R3

  AST_IDLE_PIN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((remoteIrrClr & (entMask | ~pending)) != '0 && !timerRunning)
      |=> !serviceReq); // R4
endmodule

bind eoi_storm_throttle eoi_storm_throttle_chk #(
  .NUM_PINS(NUM_PINS), .EXPLICIT_VER(EXPLICIT_VER)
) u_chk (
  .clk(clk), .rstN(rstN), .eoiValid(eoiValid), .eoiFromReg(eoiFromReg),
  .hwVersion(hwVersion), .entMask(entMask), .pending(pending),
  .remoteIrrClr(remoteIrrClr), .serviceReq(serviceReq),
  .workSet(workSet), .timerRunning(timerRunning)
);

// File: tb/eoi_storm_throttle_bench.sv
`timescale 1ns/1ps
module eoi_storm_throttle_bench;
  localparam int NP  = 8;
  localparam int LIM = 4;
  localparam int DLY = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          eoiValid = 1'b0;
  logic          eoiFromReg = 1'b0;
  logic [7:0]    eoiVector = '0;
  logic [7:0]    hwVersion = 8'h20;
  logic [NP*8-1:0] entVector = '0;
  logic [NP-1:0] entLevel = '0;
  logic [NP-1:0] entMask = '0;
  logic [NP-1:0] entRemoteIrr = '0;
  logic [NP-1:0] pending = '0;
  logic [NP-1:0] entryWrite = '0;
  logic [NP-1:0] remoteIrrClr;
  logic          serviceReq;

  logic [NP-1:0] clrSeen;
  logic          reqSeen;
  int checkCnt = 0;
  int failCnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  eoi_storm_throttle #(
    .NUM_PINS(NP), .VEC_W(8), .STORM_LIMIT(LIM), .DELAY_CYCLES(DLY),
    .EXPLICIT_VER(8'h20)
  ) u_eoi_storm_throttle (
    .clk(clk), .rstN(rstN), .eoiValid(eoiValid), .eoiFromReg(eoiFromReg),
    .eoiVector(eoiVector), .hwVersion(hwVersion), .entVector(entVector),
    .entLevel(entLevel), .entMask(entMask), .entRemoteIrr(entRemoteIrr),
    .pending(pending), .entryWrite(entryWrite),
    .remoteIrrClr(remoteIrrClr), .serviceReq(serviceReq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // one cycle: sample at the falling edge, model the flag clear
  task automatic tick();
    @(negedge clk);
    clrSeen = remoteIrrClr;
    reqSeen = serviceReq;
    entRemoteIrr = entRemoteIrr & ~clrSeen;
  endtask

  task automatic setEntry(input int pin, input logic [7:0] vec, input bit lvl,
                          input bit msk, input bit rirr);
    entVector[pin*8 +: 8] = vec;
    entLevel[pin] = lvl;
    entMask[pin] = msk;
    entRemoteIrr[pin] = rirr;
  endtask

  task automatic pulseEoi(input logic [7:0] vec, input bit fromReg);
    eoiVector = vec;
    eoiFromReg = fromReg;
    eoiValid = 1'b1;
    tick();
    eoiValid = 1'b0;
  endtask

  task automatic writeEntry(input int pin);
    entryWrite[pin] = 1'b1;
    tick();
    entryWrite = '0;
  endtask

  // one acknowledge on pin 4 with vector 0x50, expecting an immediate request
  task automatic ackImmediate(input string req, input bit expReq);
    entRemoteIrr[4] = 1'b1;
    pulseEoi(8'h50, 1'b0);
    check(clrSeen == NP'(1 << 4), req, "clear pin4", clrSeen, 1 << 4);
    tick();
    check(reqSeen == expReq, req, "immediate request", reqSeen, expReq);
    tick();
  endtask

  task automatic testReset();
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    check(clrSeen == '0, "R9", "clear after reset", clrSeen, 0);
    check(reqSeen == 1'b0, "R9", "request after reset", reqSeen, 0);
  endtask

  task automatic testMatch();
    setEntry(1, 8'h40, 1, 0, 1);
    setEntry(2, 8'h40, 1, 0, 0);
    setEntry(3, 8'h40, 1, 0, 1);
    setEntry(5, 8'h40, 0, 0, 1);
    setEntry(6, 8'h41, 1, 0, 1);
    pending = '0;
    pulseEoi(8'h40, 1'b0);
    check(clrSeen == NP'(1 << 1), "R2", "first clear pin1", clrSeen, 1 << 1);
    tick();
    check(clrSeen == NP'(1 << 3), "R2", "second clear pin3", clrSeen, 1 << 3);
    check(reqSeen == 1'b0, "R4", "no request when not pending", reqSeen, 0);
    tick();
    check(clrSeen == '0, "R1", "no further clear", clrSeen, 0);
    check(reqSeen == 1'b0, "R4", "no request pin3", reqSeen, 0);
    check(entRemoteIrr[5] && entRemoteIrr[6], "R1", "edge pin5 and other vector pin6 kept",
          {entRemoteIrr[6], entRemoteIrr[5]}, 2'b11);
    entRemoteIrr = '0;
    tick();
  endtask

  task automatic testImmediate();
    setEntry(4, 8'h50, 1, 0, 0);
    pending[4] = 1'b1;
    writeEntry(4);
    ackImmediate("R3", 1'b1);
    check(reqSeen == 1'b0, "R3", "request is one pulse", reqSeen, 0);
  endtask

  task automatic testStorm();
    writeEntry(4);
    for (int k = 0; k < LIM - 1; k++) ackImmediate("R5", 1'b1);
    entRemoteIrr[4] = 1'b1;
    pulseEoi(8'h50, 1'b0);
    check(clrSeen == NP'(1 << 4), "R5", "storm clear pin4", clrSeen, 1 << 4);
    begin
      int early = 0;
      for (int c = 1; c <= DLY; c++) begin
        tick();
        if (reqSeen) early++;
      end
      check(early == 0, "R5", "no request before the delay", early, 0);
    end
    tick();
    check(reqSeen == 1'b1, "R5", "deferred request due", reqSeen, 1);
    tick();
    check(reqSeen == 1'b0, "R5", "deferred request is one pulse", reqSeen, 0);
    ackImmediate("R5", 1'b1);
  endtask

  task automatic testEntryWrite();
    writeEntry(4);
    for (int k = 0; k < LIM - 1; k++) ackImmediate("R6", 1'b1);
    writeEntry(4);
    for (int k = 0; k < LIM - 1; k++) ackImmediate("R6", 1'b1);
    writeEntry(4);
  endtask

  task automatic testIdleReset();
    for (int k = 0; k < LIM - 1; k++) ackImmediate("R4", 1'b1);
    pending[4] = 1'b0;
    ackImmediate("R4", 1'b0);
    pending[4] = 1'b1;
    for (int k = 0; k < LIM - 1; k++) ackImmediate("R4", 1'b1);
    entMask[4] = 1'b1;
    ackImmediate("R4", 1'b0);
    entMask[4] = 1'b0;
    writeEntry(4);
  endtask

  task automatic testVersion();
    hwVersion = 8'h11;
    entRemoteIrr[4] = 1'b1;
    pulseEoi(8'h50, 1'b1);
    check(clrSeen == '0, "R7", "register EOI ignored at 0x11", clrSeen, 0);
    tick();
    check(clrSeen == '0 && entRemoteIrr[4], "R7", "flag kept at 0x11", entRemoteIrr[4], 1);
    pulseEoi(8'h50, 1'b0);
    check(clrSeen == NP'(1 << 4), "R7", "broadcast accepted at 0x11", clrSeen, 1 << 4);
    tick(); tick();
    hwVersion = 8'h20;
    entRemoteIrr[4] = 1'b1;
    pulseEoi(8'h50, 1'b1);
    check(clrSeen == NP'(1 << 4), "R7", "register EOI accepted at 0x20", clrSeen, 1 << 4);
    tick(); tick();
    writeEntry(4);
  endtask

  task automatic testRearm();
    setEntry(7, 8'h50, 1, 0, 0);
    pending[7] = 1'b1;
    writeEntry(7);
    writeEntry(4);
    for (int k = 0; k < LIM - 1; k++) begin
      entRemoteIrr[4] = 1'b1;
      entRemoteIrr[7] = 1'b1;
      pulseEoi(8'h50, 1'b0);
      tick(); tick(); tick();
    end
    entRemoteIrr[4] = 1'b1;
    entRemoteIrr[7] = 1'b1;
    pulseEoi(8'h50, 1'b0);
    check(clrSeen == NP'(1 << 4), "R8", "storm clear pin4", clrSeen, 1 << 4);
    tick();
    check(clrSeen == NP'(1 << 7), "R8", "storm clear pin7", clrSeen, 1 << 7);
    begin
      int early = 0;
      if (reqSeen) early++;
      for (int c = 2; c <= DLY; c++) begin
        tick();
        if (reqSeen) early++;
      end
      check(early == 0, "R8", "no request before first deadline", early, 0);
    end
    tick();
    check(reqSeen == 1'b1, "R8", "request at earlier deadline", reqSeen, 1);
    tick();
    check(reqSeen == 1'b0, "R8", "no second deferred request", reqSeen, 0);
    tick();
    check(reqSeen == 1'b0, "R8", "still quiet", reqSeen, 0);
    pending = '0;
  endtask

  task automatic testMerge();
    entRemoteIrr = '0;
    setEntry(1, 8'h40, 1, 0, 1);
    setEntry(3, 8'h40, 1, 0, 1);
    setEntry(6, 8'h41, 1, 0, 1);
    pulseEoi(8'h40, 1'b0);
    check(clrSeen == NP'(1 << 1), "R10", "first scan pin1", clrSeen, 1 << 1);
    pulseEoi(8'h41, 1'b0);
    check(clrSeen == NP'(1 << 3), "R10", "first scan pin3", clrSeen, 1 << 3);
    tick();
    check(clrSeen == NP'(1 << 6), "R10", "merged pin6", clrSeen, 1 << 6);
    tick();
    check(clrSeen == '0, "R10", "scan finished", clrSeen, 0);
  endtask

  initial begin
    testReset();
    testMatch();
    testImmediate();
    testStorm();
    testEntryWrite();
    testIdleReset();
    testVersion();
    testRearm();
    testMerge();
    done = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end
endmodule